// File: doc/BRIEF.md
# SM4 Four-Round Step Unit

This block advances an SM4 cipher state by exactly four rounds per operation. The caller hands over a 128-bit state, seen as four 32-bit words, together with a group of four 32-bit round keys. The block returns the next four state words. A full 32-round encryption is eight operations in a row, with the round keys fed in groups of four in schedule order. Decryption uses the same operation with the schedule fed in reverse order. Key expansion and the final word reversal at the end of the cipher are left to the caller.

The block computes one round per clock cycle on a single shared round datapath. Operations enter through a valid/ready handshake and leave through another. A one-bit key mode chooses how keys are taken. In per-operation mode, every operation uses its own key port. In shared mode, one key group is captured at the start of a run of shared-mode operations and is reused by every later operation of that run. This matches the case where one key group serves many state groups.

Top module: `sm4_round4_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: The result equals four rounds of X[i+4] = X[i] ^ L(T(X[i+1]^X[i+2]^X[i+3]^rk[i])). Here L(B) = B ^ (B<<<2) ^ (B<<<10) ^ (B<<<18) ^ (B<<<24). T applies the SM4 S-box to each byte. The S-box is S(x) = A·inv(A·x ^ 0xD3) ^ 0xD3, with the inverse taken in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1 (and inv(0)=0). Output bit k of A·v is the parity of v AND rotl8(0xA7,k).
- R3: State word X[0] is `in_state[127:96]`, down to X[3] at `[31:0]`. Key rk[0] is `in_keys[127:96]`, down to rk[3] at `[31:0]`. The output is {X[4],X[5],X[6],X[7]}, with X[4] at `[127:96]`.
- R4: `out_valid` first reads 1 after the fourth rising edge that follows the accepting edge.
- R5: From acceptance until the result is taken, `in_ready` is 0, and `in_valid` has no effect on the pending result.
- R6: While `out_valid` is 1 and `out_ready` is 0, both `out_valid` and `out_state` hold.
- R7: With `key_mode`=0 at acceptance, the operation uses that cycle's `in_keys`.
- R8: With `key_mode`=1 at acceptance, the first such operation after reset, or after a `key_mode`=0 operation, captures `in_keys`. Every following consecutive `key_mode`=1 operation ignores `in_keys` and reuses the captured group.
- R9: Eight chained operations with the 32 round keys of the standard test key reproduce the known ciphertext in unreversed word order. Chaining the reversed key order over the ciphertext recovers the plaintext.
- R10: `in_ready` returns to 1 in the cycle after the result handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | Block is idle and accepts an operation |
| key_mode | input | 1 | 0 = keys per operation, 1 = shared key group per run |
| in_state | input | 128 | Four input state words, X[0] in the top word |
| in_keys | input | 128 | Four round keys, rk[0] in the top word |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_state | output | 128 | Four new state words, X[4] in the top word |

## Verification
One wrong S-box entry or rotation amount corrupts the new word of the round that uses it, so the error shows in the very next result. It also cascades through the later rounds, which makes the known-answer chain sensitive to any single defect. A wrong round counter shows as a shifted word order or a result that arrives one cycle early or late, and is seen at the first handshake. A wrong captured key group in shared mode shows only on the second and later operations of a run. The bench therefore checks runs of three or more operations with changing key inputs.

// File: rtl/sm4_pkg.sv
package sm4_pkg;

  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int NWORDS   = 4;
  localparam int STATE_W  = WORD_W * NWORDS;
  localparam int NBYTES   = WORD_W / BYTE_W;
  localparam logic [7:0] FIELD_LOW = 8'hF5;  // x^8 term implied
  localparam logic [7:0] AFF_ROW   = 8'hA7;
  localparam logic [7:0] AFF_CONST = 8'hD3;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} step_state_e;

  // GF(2^8) multiply, shift-and-add with reduction each step
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[7] ? ((sh << 1) ^ FIELD_LOW) : (sh << 1);
    end
    return acc;
  endfunction

  // x^254 gives the inverse; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] r;
    sq = x;
    r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] v);
    logic [15:0] rot;
    logic [7:0]  o;
    for (int k = 0; k < 8; k++) begin
      rot  = {AFF_ROW, AFF_ROW} << k;
      o[k] = ^(v & rot[15:8]);
    end
    return o;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    return affine(gf_inv(affine(x) ^ AFF_CONST)) ^ AFF_CONST;
  endfunction

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] lin_mix(input logic [WORD_W-1:0] b);
    return b ^ rotl(b, 2) ^ rotl(b, 10) ^ rotl(b, 18) ^ rotl(b, 24);
  endfunction

endpackage

// File: rtl/sm4_sbox8.sv
module sm4_sbox8 (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  always_comb dout = sm4_pkg::sbox(din);
endmodule

// File: rtl/sm4_round_core.sv
module sm4_round_core
  import sm4_pkg::*;
(
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  input  logic [WORD_W-1:0] w3,
  input  logic [WORD_W-1:0] rk,
  output logic [WORD_W-1:0] w_new
);
  logic [WORD_W-1:0] mixed;
  logic [WORD_W-1:0] subst;

  assign mixed = w1 ^ w2 ^ w3 ^ rk;

  for (genvar b = 0; b < NBYTES; b++) begin : g_sbox
    sm4_sbox8 u_sbox (
      .din  (mixed[b*BYTE_W +: BYTE_W]),
      .dout (subst[b*BYTE_W +: BYTE_W])
    );
  end

  assign w_new = w0 ^ lin_mix(subst);
endmodule

// File: rtl/sm4_key_hold.sv
module sm4_key_hold #(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             key_mode,
  input  logic [KEY_W-1:0] in_keys,
  output logic [KEY_W-1:0] keys_sel,
  output logic [KEY_W-1:0] held_keys,
  output logic             burst_live,
  output logic             key_reload
);
  assign key_reload = accept && key_mode && !burst_live;
  assign keys_sel   = (key_mode && burst_live) ? held_keys : in_keys;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_live <= 1'b0;
      held_keys  <= '0;
    end else begin
      if (accept)     burst_live <= key_mode;
      if (key_reload) held_keys  <= in_keys;
    end
  end
endmodule

// File: rtl/sm4_step_ctrl.sv
module sm4_step_ctrl
  import sm4_pkg::*;
#(
  parameter int ROUNDS = 4,
  localparam int IDX_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic accept,
  output logic round_fire,
  output logic last_round
);
  step_state_e      st;
  logic [IDX_W-1:0] idx;

  assign in_ready   = (st == ST_IDLE);
  assign out_valid  = (st == ST_DONE);
  assign accept     = in_ready && in_valid;
  assign round_fire = (st == ST_RUN);
  assign last_round = round_fire && (idx == IDX_W'(ROUNDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st  <= ST_RUN;
          idx <= '0;
        end
        ST_RUN: begin
          idx <= idx + 1'b1;
          if (last_round) st <= ST_DONE;
        end
        ST_DONE: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sm4_round4_unit.sv
module sm4_round4_unit
  import sm4_pkg::*;
#(
  parameter int ROUNDS = 4,
  localparam int KEY_W = ROUNDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               key_mode,
  input  logic [STATE_W-1:0] in_state,
  input  logic [KEY_W-1:0]   in_keys,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [STATE_W-1:0] out_state
);
  logic              accept;
  logic              round_fire;
  logic              last_round;
  logic              key_reload;
  logic              burst_live;
  logic [KEY_W-1:0]  keys_sel;
  logic [KEY_W-1:0]  held_keys;
  logic [KEY_W-1:0]  key_sr;
  logic [WORD_W-1:0] sw [NWORDS];
  logic [WORD_W-1:0] w_new;
  logic [WORD_W-1:0] rk_now;

  sm4_step_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .accept     (accept),
    .round_fire (round_fire),
    .last_round (last_round)
  );

  sm4_key_hold #(.KEY_W(KEY_W)) u_keys (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .key_mode   (key_mode),
    .in_keys    (in_keys),
    .keys_sel   (keys_sel),
    .held_keys  (held_keys),
    .burst_live (burst_live),
    .key_reload (key_reload)
  );

  assign rk_now = key_sr[KEY_W-1 -: WORD_W];

  sm4_round_core u_core (
    .w0    (sw[0]),
    .w1    (sw[1]),
    .w2    (sw[2]),
    .w3    (sw[3]),
    .rk    (rk_now),
    .w_new (w_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_sr <= '0;
      for (int i = 0; i < NWORDS; i++) sw[i] <= '0;
    end else if (accept) begin
      key_sr <= keys_sel;
      for (int i = 0; i < NWORDS; i++)
        sw[i] <= in_state[(NWORDS-1-i)*WORD_W +: WORD_W];
    end else if (round_fire) begin
      key_sr <= key_sr << WORD_W;
      for (int i = 0; i < NWORDS-1; i++) sw[i] <= sw[i+1];
      sw[NWORDS-1] <= w_new;
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_out
    assign out_state[(NWORDS-1-i)*WORD_W +: WORD_W] = sw[i];
  end
endmodule

// File: rtl/sm4_round4_chk.sv
module sm4_round4_chk #(
  parameter int KEY_W   = 128,
  parameter int STATE_W = 128,
  parameter int ROUNDS  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               key_mode,
  input logic [KEY_W-1:0]   in_keys,
  input logic               out_valid,
  input logic               out_ready,
  input logic [STATE_W-1:0] out_state,
  input logic               accept,
  input logic               round_fire,
  input logic               last_round,
  input logic               burst_live,
  input logic [KEY_W-1:0]   held_keys
);
  logic [7:0] fires;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fires <= '0;
    else if (accept)     fires <= '0;
    else if (round_fire) fires <= fires + 1'b1;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_state)));

  assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, round_fire, out_valid}));

  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (fires == 8'(ROUNDS)));

  assert_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> out_valid);

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && key_mode && !burst_live) |=> (burst_live && held_keys == $past(in_keys)));

  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && key_mode && burst_live) |=> (burst_live && $stable(held_keys)));

  assert_runend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !key_mode) |=> !burst_live);

  wire unused_ok = in_valid;
endmodule

bind sm4_round4_unit sm4_round4_chk #(
  .KEY_W   (KEY_W),
  .STATE_W (sm4_pkg::STATE_W),
  .ROUNDS  (ROUNDS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .key_mode   (key_mode),
  .in_keys    (in_keys),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_state  (out_state),
  .accept     (accept),
  .round_fire (round_fire),
  .last_round (last_round),
  .burst_live (burst_live),
  .held_keys  (held_keys)
);

// File: tb/test_sm4_round4_unit.sv
module test_sm4_round4_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         key_mode;
  logic         out_ready;
  logic [127:0] in_state;
  logic [127:0] in_keys;
  wire          in_ready;
  wire          out_valid;
  wire [127:0]  out_state;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [7:0]  sb [256];
  logic [31:0] rks [32];

  always #2.5 clk = ~clk;

  sm4_round4_unit i_sm4_round4_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .key_mode(key_mode), .in_state(in_state), .in_keys(in_keys),
    .out_valid(out_valid), .out_ready(out_ready), .out_state(out_state)
  );

  // carry-less product, then fold down the high bits
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h1F5 << (i - 8));
    return p[7:0];
  endfunction

  // matrix times vector as a sum of columns
  function automatic logic [7:0] m_aff(input logic [7:0] v);
    logic [7:0] acc;
    logic [7:0] col;
    acc = '0;
    for (int j = 0; j < 8; j++) begin
      col = '0;
      for (int k = 0; k < 8; k++) col[k] = 8'hA7 >> ((j - k + 8) % 8);
      if (v[j]) acc = acc ^ col;
    end
    return acc;
  endfunction

  function automatic logic [31:0] t_sub(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    logic [63:0] d;
    d = {v, v} << n;
    return d[63:32];
  endfunction

  function automatic logic [31:0] l_enc(input logic [31:0] b);
    return b ^ rl(b, 2) ^ rl(b, 10) ^ rl(b, 18) ^ rl(b, 24);
  endfunction

  function automatic logic [31:0] l_key(input logic [31:0] b);
    return b ^ rl(b, 13) ^ rl(b, 23);
  endfunction

  function automatic logic [127:0] model_op(input logic [127:0] s, input logic [127:0] k);
    logic [31:0] x [8];
    for (int i = 0; i < 4; i++) x[i] = s[127 - 32*i -: 32];
    for (int r = 0; r < 4; r++)
      x[r+4] = x[r] ^ l_enc(t_sub(x[r+1] ^ x[r+2] ^ x[r+3] ^ k[127 - 32*r -: 32]));
    return {x[4], x[5], x[6], x[7]};
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation; stall = cycles of held-off out_ready, junk = offer in_valid while busy
  task automatic run_op(input logic [127:0] st, input logic [127:0] k, input bit md,
                        input int stall, input bit junk,
                        output logic [127:0] res, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_state = st; in_keys = k; key_mode = md;
    @(posedge clk);
    @(negedge clk);
    lat = 0;
    if (junk) begin
      in_valid = 1'b1; in_state = rnd128(); in_keys = rnd128(); key_mode = 1'b0;
    end else begin
      in_valid = 1'b0; in_keys = rnd128();
    end
    while (!out_valid && lat < 20) begin
      if (junk) chk(in_ready == 1'b0, "R5 busy in_ready", 128'(in_ready), 128'h0);
      @(negedge clk);
      lat++;
    end
    res = out_state;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_state == res, "R6 hold under backpressure", out_state, res);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R10 ready after handshake",
        128'({in_ready, out_valid}), 128'h2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog: no completion actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] res, exp, st, k, kshared, ct;
    logic [31:0]  kk [36];
    logic [31:0]  x4;
    int lat;

    void'($urandom(32'h5A17C3));
    rst_n = 1'b0; in_valid = 1'b0; key_mode = 1'b0; out_ready = 1'b0;
    in_state = '0; in_keys = '0;

    // bench S-box: inverse by search, affine by columns
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv, y;
      y = m_aff(8'(a)) ^ 8'hD3;
      inv = 8'h00;
      for (int b = 1; b < 256; b++) if (m_mul(y, 8'(b)) == 8'h01) inv = 8'(b);
      sb[a] = m_aff(inv) ^ 8'hD3;
    end

    // key schedule for the standard test key
    kk[0] = 32'h01234567 ^ 32'hA3B1BAC6;
    kk[1] = 32'h89ABCDEF ^ 32'h56AA3350;
    kk[2] = 32'hFEDCBA98 ^ 32'h677D9197;
    kk[3] = 32'h76543210 ^ 32'hB27022DC;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] ck;
      for (int j = 0; j < 4; j++) ck[31 - 8*j -: 8] = 8'((4*i + j) * 7);
      kk[i+4] = kk[i] ^ l_key(t_sub(kk[i+1] ^ kk[i+2] ^ kk[i+3] ^ ck));
      rks[i] = kk[i+4];
    end

    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 during reset", 128'({in_ready, out_valid}), 128'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", 128'({in_ready, out_valid}), 128'h2);

    // all-zero operands
    run_op('0, '0, 1'b0, 0, 1'b0, res, lat);
    chk(res == model_op('0, '0), "R2 zero operands", res, model_op('0, '0));
    chk(lat == 4, "R4 latency", 128'(lat), 128'd4);

    // word placement: first new word sits in the top slot
    st = rnd128(); k = rnd128();
    run_op(st, k, 1'b0, 0, 1'b0, res, lat);
    x4 = st[127:96] ^ l_enc(t_sub(st[95:64] ^ st[63:32] ^ st[31:0] ^ k[127:96]));
    chk(res[127:96] == x4, "R3 word order", 128'(res[127:96]), 128'(x4));
    chk(res == model_op(st, k), "R2 random single", res, model_op(st, k));

    // all-ones corner
    run_op({128{1'b1}}, {128{1'b1}}, 1'b0, 0, 1'b0, res, lat);
    exp = model_op({128{1'b1}}, {128{1'b1}});
    chk(res == exp, "R2 all ones", res, exp);

    // known-answer encryption chain
    st = 128'h0123456789ABCDEFFEDCBA9876543210;
    for (int g = 0; g < 8; g++) begin
      run_op(st, {rks[4*g], rks[4*g+1], rks[4*g+2], rks[4*g+3]}, 1'b0, 0, 1'b0, res, lat);
      st = res;
    end
    chk(st == 128'h536E424686B3E94FD206965E681EDF34, "R9 encrypt chain",
        st, 128'h536E424686B3E94FD206965E681EDF34);

    // decryption: reversed ciphertext words, reversed keys
    ct = 128'h681EDF34D206965E86B3E94F536E4246;
    st = ct;
    for (int g = 0; g < 8; g++) begin
      run_op(st, {rks[31-4*g], rks[30-4*g], rks[29-4*g], rks[28-4*g]}, 1'b0, 0, 1'b0, res, lat);
      st = res;
    end
    chk(st == 128'h76543210FEDCBA9889ABCDEF01234567, "R9 decrypt chain",
        st, 128'h76543210FEDCBA9889ABCDEF01234567);

    // busy-time input and backpressure
    st = rnd128(); k = rnd128();
    run_op(st, k, 1'b0, 3, 1'b1, res, lat);
    chk(res == model_op(st, k), "R5 result unaffected by busy input", res, model_op(st, k));
    chk(lat == 4, "R4 latency with junk", 128'(lat), 128'd4);

    // per-operation keys, random
    for (int n = 0; n < 30; n++) begin
      st = rnd128(); k = rnd128();
      run_op(st, k, 1'b0, n % 3, 1'b0, res, lat);
      chk(res == model_op(st, k), "R7 per-op keys", res, model_op(st, k));
    end

    // shared-key run
    kshared = rnd128();
    st = rnd128();
    run_op(st, kshared, 1'b1, 0, 1'b0, res, lat);
    chk(res == model_op(st, kshared), "R8 run start captures", res, model_op(st, kshared));
    for (int n = 0; n < 3; n++) begin
      st = rnd128();
      run_op(st, rnd128(), 1'b1, 1, 1'b0, res, lat);
      chk(res == model_op(st, kshared), "R8 run reuses captured keys", res, model_op(st, kshared));
    end

    // per-op operation ends the run, next shared op recaptures
    st = rnd128(); k = rnd128();
    run_op(st, k, 1'b0, 0, 1'b0, res, lat);
    chk(res == model_op(st, k), "R7 per-op between runs", res, model_op(st, k));
    kshared = rnd128();
    st = rnd128();
    run_op(st, kshared, 1'b1, 0, 1'b0, res, lat);
    chk(res == model_op(st, kshared), "R8 new run captures", res, model_op(st, kshared));
    st = rnd128();
    run_op(st, rnd128(), 1'b1, 0, 1'b0, res, lat);
    chk(res == model_op(st, kshared), "R8 new run reuses", res, model_op(st, kshared));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule